// File: doc/BRIEF.md
# Track Verify Checker

This block confirms, after a head-positioning command that asked for verification, that the read/write head really sits over the intended track. A command controller pulses `start` together with the verify request. The block then waits until the head has finished settling. After that it watches the stream of decoded ID-field reports. Each report carries a track byte and a flag that tells whether the ID field's CRC was correct.

The check succeeds on the first report whose track byte equals the current track register and whose CRC is good. A report with a matching track but a bad CRC raises a sticky CRC-error flag, and the search continues. Reports whose track byte differs are skipped. The search is bounded by disk revolutions, which are counted on rising edges of the index input. When the revolution budget runs out, the block raises the seek-error flag. Either ending produces a one-cycle `done` pulse that the controller turns into an interrupt. Both error flags stay valid until the next `start`.

Top module: `trk_verify`

## Requirements
- R1: While the block waits for `settle_done`, ID reports and index edges are ignored. They neither end the check, nor set a flag, nor count toward the revolution budget.
- R2: An ID report is considered only when `id_track` equals `track_reg`. A mismatching report has no effect, whatever its CRC flag.
- R3: A matching report with `id_crc_ok`=1 makes `done` high for exactly one cycle, in the cycle after the report is sampled. In that same cycle `busy` goes low, and the report sets no error flag.
- R4: A matching report with `id_crc_ok`=0 sets `crc_err` in the cycle after it is sampled. Checking then continues with `busy` still high.
- R5: Once set, `crc_err` stays high through a later successful match and while idle. Only a new `start` clears it.
- R6: During checking, the (REV_LIMIT+1)-th index rising edge (the 6th by default) ends the check. It sets `seek_err` and pulses `done`. If a good matching report is sampled in the same cycle, the check ends as a success with no `seek_err`.
- R7: A `start` with `vfy`=0 performs no check. `busy` stays low, and no later ID report produces `done`.
- R8: `start` clears `crc_err` and `seek_err` in the next cycle. A `start` while busy abandons the current check and begins a new one.
- R9: Revolutions are counted on rising edges of `index`. An index level held high for many cycles counts once.
- R10: After reset `busy`, `done`, `crc_err` and `seek_err` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | New positioning command finished stepping; begins a check |
| vfy | input | 1 | Verify request, sampled with `start` |
| settle_done | input | 1 | Head settling period has ended |
| index | input | 1 | Index sensor level |
| id_valid | input | 1 | Strobe for one decoded ID-field report |
| id_track | input | TRK_W | Track byte from the ID field |
| id_crc_ok | input | 1 | ID-field CRC was correct |
| track_reg | input | TRK_W | Current track register value |
| busy | output | 1 | A check is in progress (settling or searching) |
| done | output | 1 | One-cycle pulse when a check ends |
| crc_err | output | 1 | A matching ID had a bad CRC during this check |
| seek_err | output | 1 | No good matching ID within the revolution budget |

## Verification
The main search is driven with several report sequences: an immediate good match, mismatching tracks with good and bad CRC ahead of a good match, and repeated bad-CRC matches before a good one. Together these separate the track compare from the CRC test and show that the CRC flag is sticky. Index patterns cover five pulses (which must not time out), a sixth pulse (which must), a long high level (which must count once), and pulses sent before settling (which must not count). A good match that arrives on the same edge as the final index pulse shows which outcome takes priority. Starts with the verify request cleared, and starts issued in the middle of a check, show that nothing runs in the first case and that the flags clear in both.

// File: rtl/trk_verify.sv
module trk_verify #(
  parameter int TRK_W     = 8,
  parameter int REV_LIMIT = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             vfy,
  input  logic             settle_done,
  input  logic             index,
  input  logic             id_valid,
  input  logic [TRK_W-1:0] id_track,
  input  logic             id_crc_ok,
  input  logic [TRK_W-1:0] track_reg,
  output logic             busy,
  output logic             done,
  output logic             crc_err,
  output logic             seek_err
);
  localparam int CNT_W = $clog2(REV_LIMIT + 2);

  typedef enum logic [1:0] {S_IDLE, S_SETTLE, S_CHECK} st_t;

  st_t              st;
  logic [CNT_W-1:0] revs;
  logic             idx_q;

  wire in_chk   = (st == S_CHECK);
  wire idx_rise = index & ~idx_q;
  wire id_hit   = in_chk & id_valid & (id_track == track_reg);
  wire good     = id_hit & id_crc_ok;
  wire last_rev = in_chk & idx_rise & (revs == CNT_W'(REV_LIMIT));

  assign busy = (st != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      revs     <= '0;
      idx_q    <= 1'b0;
      done     <= 1'b0;
      crc_err  <= 1'b0;
      seek_err <= 1'b0;
    end else begin
      idx_q <= index;
      done  <= 1'b0;
      if (start) begin
        crc_err  <= 1'b0;
        seek_err <= 1'b0;
        revs     <= '0;
        st       <= vfy ? S_SETTLE : S_IDLE;
      end else begin
        case (st)
          S_SETTLE: if (settle_done) st <= S_CHECK;
          S_CHECK: begin
            if (id_hit && !id_crc_ok) crc_err <= 1'b1;
            if (good) begin
              done <= 1'b1;
              st   <= S_IDLE;
            end else if (last_rev) begin
              seek_err <= 1'b1;
              done     <= 1'b1;
              st       <= S_IDLE;
            end else if (idx_rise) begin
              revs <= revs + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/trk_verify_chk.sv
module trk_verify_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       vfy,
  input logic       settle_done,
  input logic [1:0] st,
  input logic       busy,
  input logic       done,
  input logic       crc_err,
  input logic       seek_err
);
  p_settle_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd1 && !settle_done && !start) |=> (busy && !done));

  p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_crc_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (crc_err && !start) |=> crc_err);

  p_seek_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(seek_err) |-> done);

  p_no_verify_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !vfy) |=> !busy);

  p_start_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (!crc_err && !seek_err));
endmodule

bind trk_verify trk_verify_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .vfy(vfy),
  .settle_done(settle_done), .st(st), .busy(busy), .done(done),
  .crc_err(crc_err), .seek_err(seek_err)
);

// File: tb/trk_verify_test.sv
module trk_verify_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0, vfy = 1'b0, settle_done = 1'b0, index = 1'b0;
  logic       id_valid = 1'b0, id_crc_ok = 1'b0;
  logic [7:0] id_track = '0, track_reg = 8'd12;
  logic       busy, done, crc_err, seek_err;
  int checks = 0, failures = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  trk_verify uut (.*);

  task automatic chk(string tag, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  task automatic do_start(logic v);
    @(negedge clk); start = 1'b1; vfy = v;
    @(negedge clk); start = 1'b0; vfy = 1'b0;
  endtask

  task automatic do_settle();
    @(negedge clk); settle_done = 1'b1;
    @(negedge clk); settle_done = 1'b0;
  endtask

  task automatic do_id(logic [7:0] t, logic ok);
    @(negedge clk); id_valid = 1'b1; id_track = t; id_crc_ok = ok;
    @(negedge clk); id_valid = 1'b0;
  endtask

  task automatic do_idx(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); index = 1'b1;
      @(negedge clk); index = 1'b0;
    end
  endtask

  task automatic t_reset();
    chk("R10", "busy", busy, 1'b0);
    chk("R10", "done", done, 1'b0);
    chk("R10", "crc_err", crc_err, 1'b0);
    chk("R10", "seek_err", seek_err, 1'b0);
  endtask

  task automatic t_good();
    do_start(1'b1);
    chk("R3", "busy after start", busy, 1'b1);
    do_settle();
    do_id(8'd12, 1'b1);
    chk("R3", "done", done, 1'b1);
    chk("R3", "busy", busy, 1'b0);
    chk("R3", "crc_err", crc_err, 1'b0);
    chk("R3", "seek_err", seek_err, 1'b0);
    @(negedge clk);
    chk("R3", "done one cycle", done, 1'b0);
  endtask

  task automatic t_early();
    do_start(1'b1);
    do_id(8'd12, 1'b1);
    chk("R1", "done before settle", done, 1'b0);
    do_id(8'd12, 1'b0);
    chk("R1", "crc before settle", crc_err, 1'b0);
    do_idx(7);
    chk("R1", "busy before settle", busy, 1'b1);
    do_settle();
    do_idx(5);
    chk("R1", "early index uncounted", busy, 1'b1);
    chk("R1", "no seek", seek_err, 1'b0);
    do_id(8'd12, 1'b1);
    chk("R1", "done after settle", done, 1'b1);
  endtask

  task automatic t_mismatch();
    do_start(1'b1);
    do_settle();
    do_id(8'd13, 1'b0);
    chk("R2", "mismatch bad crc ignored", crc_err, 1'b0);
    chk("R2", "busy", busy, 1'b1);
    do_id(8'd13, 1'b1);
    chk("R2", "mismatch good no done", done, 1'b0);
    chk("R2", "busy", busy, 1'b1);
    do_id(8'd12, 1'b1);
    chk("R2", "match done", done, 1'b1);
  endtask

  task automatic t_crc();
    do_start(1'b1);
    do_settle();
    do_id(8'd12, 1'b0);
    chk("R4", "crc_err set", crc_err, 1'b1);
    chk("R4", "still busy", busy, 1'b1);
    chk("R4", "no done", done, 1'b0);
    do_id(8'd12, 1'b0);
    do_id(8'd12, 1'b1);
    chk("R5", "done", done, 1'b1);
    chk("R5", "crc kept on success", crc_err, 1'b1);
    chk("R5", "seek clear", seek_err, 1'b0);
    repeat (5) @(negedge clk);
    chk("R5", "crc kept idle", crc_err, 1'b1);
    do_start(1'b1);
    chk("R8", "start clears crc", crc_err, 1'b0);
  endtask

  task automatic t_timeout();
    do_settle();
    do_idx(5);
    chk("R6", "busy after 5", busy, 1'b1);
    chk("R6", "no seek after 5", seek_err, 1'b0);
    @(negedge clk); index = 1'b1;
    @(negedge clk); index = 1'b0;
    chk("R6", "done on 6th", done, 1'b1);
    chk("R6", "seek on 6th", seek_err, 1'b1);
    repeat (3) @(negedge clk);
    chk("R6", "seek held", seek_err, 1'b1);
    do_start(1'b1);
    chk("R8", "start clears seek", seek_err, 1'b0);
  endtask

  task automatic t_level();
    do_settle();
    @(negedge clk); index = 1'b1;
    repeat (10) @(negedge clk);
    index = 1'b0;
    do_idx(4);
    chk("R9", "level counted once", busy, 1'b1);
    do_idx(1);
    chk("R9", "seek after 6 edges", seek_err, 1'b1);
  endtask

  task automatic t_tie();
    do_start(1'b1);
    do_settle();
    do_idx(5);
    @(negedge clk); index = 1'b1; id_valid = 1'b1; id_track = 8'd12; id_crc_ok = 1'b1;
    @(negedge clk); index = 1'b0; id_valid = 1'b0;
    chk("R6", "tie done", done, 1'b1);
    chk("R6", "tie no seek", seek_err, 1'b0);
  endtask

  task automatic t_restart();
    do_start(1'b1);
    do_settle();
    do_id(8'd12, 1'b0);
    chk("R8", "crc before restart", crc_err, 1'b1);
    do_start(1'b1);
    chk("R8", "restart clears crc", crc_err, 1'b0);
    chk("R8", "restart busy", busy, 1'b1);
    do_id(8'd12, 1'b1);
    chk("R8", "restart waits settle", done, 1'b0);
    do_settle();
    do_id(8'd12, 1'b1);
    chk("R8", "restart done", done, 1'b1);
  endtask

  task automatic t_novfy();
    do_start(1'b1);
    do_settle();
    do_id(8'd12, 1'b0);
    do_start(1'b0);
    chk("R7", "no busy", busy, 1'b0);
    chk("R8", "crc cleared", crc_err, 1'b0);
    do_settle();
    do_id(8'd12, 1'b1);
    chk("R7", "no done", done, 1'b0);
    chk("R7", "still idle", busy, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_good();
    t_early();
    t_mismatch();
    t_crc();
    t_timeout();
    t_level();
    t_tie();
    t_restart();
    t_novfy();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule